// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Critical-Word-First Line Fill

This block places a direct-mapped cache between one requesting client and a slower word-wide backing memory. Each byte address is divided into a word offset, a line index and a tag. The index picks exactly one line, and a valid line whose stored tag equals the request tag is a hit. A read hit returns data one cycle after the request is accepted. A read miss stalls the client. The cache asks memory for the line, starting with the word the client wants. Memory returns the words of the line in wrap-around order. The client is released as soon as that first word arrives, and the other words of the line keep filling in the background.

An address window is set by two inputs, a base and a mask. Addresses inside the window are never cached. Reads to them always go to memory and leave the cache unchanged. Writes are write-through and do not allocate. A write that hits updates the cached word and memory. A write that misses updates memory only. Two counters report how many reads hit and how many missed, so that a model can compare miss rates.

Control sits in a five-state machine. **IDLE** accepts any request. **CRIT_WAIT** waits for the demanded word. **BACKFILL** writes the rest of the line. **NC_WAIT** waits for the first word of an uncached read. **NC_DRAIN** discards the rest of that burst. The transitions are:
- IDLE→CRIT_WAIT on a cacheable read miss.
- IDLE→NC_WAIT on a read inside the window.
- CRIT_WAIT→BACKFILL on the first returned word.
- NC_WAIT→NC_DRAIN on the first returned word.
- BACKFILL→IDLE and NC_DRAIN→IDLE on the last word.

Top module: `dm_cache`

## Requirements
- R1: The low 2 address bits select the byte. The next log2(LINE_WORDS) bits select the word in the line. The next log2(LINES) bits select the line. The remaining upper bits form the tag. Two words of the same line both hit after one fill.
- R2: A read that hits is accepted while `req_ready` is high. `rsp_valid` pulses in the next cycle, and `rsp_rdata` carries the current memory content of that word.
- R3: A cacheable read miss pulses `mem_rd_req` in the cycle after acceptance. `mem_rd_addr` carries the word address of the demanded word, and `req_ready` is low in that cycle.
- R4: Memory returns the words of the line in wrap order, beginning with the demanded word. The client receives that first returned word.
- R5: `rsp_valid` for a miss rises in the cycle after the first returned word, while the remaining words of the line are still to come.
- R6: While a line fill is in progress, every request stalls except reads to words of the filling line that have already arrived. Such reads are accepted at once and answered as hits one cycle later.
- R7: The line being filled becomes valid, with its new tag, only after its last word is written. After that, any word of the line hits.
- R8: A read whose tag differs from the stored tag at the same index misses and replaces the line. A later read of the old tag misses again.
- R9: A read with (`req_addr` & `nc_mask`) == `nc_base` is fetched from memory and returned. It counts as a miss and is never allocated, so a repeat read misses again.
- R10: Each accepted write pulses `mem_wr_valid` in the next cycle, with the word address and the write data. A write hit also updates the cached word, so a later read hits and returns the new value.
- R11: A write miss does not allocate. A following read of that address misses and returns the written value.
- R12: After reset every line is invalid, both counters are zero, `req_ready` is high, and `rsp_valid` and `mem_rd_req` are low.
- R13: `hit_count` counts accepted read hits. `miss_count` counts accepted read misses, including window reads. Writes change neither counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nc_base | input | ADDR_W | Base of the uncached window |
| nc_mask | input | ADDR_W | Address bits compared against `nc_base` |
| req_valid | input | 1 | Client request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | WORD_W | Write data |
| req_ready | output | 1 | Request accepted this cycle when high |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | WORD_W | Read data |
| mem_rd_req | output | 1 | One-cycle burst read request |
| mem_rd_addr | output | ADDR_W-2 | Word address of the first word of the burst |
| mem_rd_valid | input | 1 | Returned word valid |
| mem_rd_data | input | WORD_W | Returned word |
| mem_wr_valid | output | 1 | Write-through pulse |
| mem_wr_addr | output | ADDR_W-2 | Word address to write |
| mem_wr_data | output | WORD_W | Word to write |
| hit_count | output | CNT_W | Read hit count |
| miss_count | output | CNT_W | Read miss count |

## Verification
The bench builds the cache with LINES = 8 and keeps the defaults of 4 words per line and 32-bit words. With only eight lines, a 512-byte range of random addresses forces frequent conflict evictions. Hits, misses and replacements all occur in a short run. Because the memory returns its first word after a fixed delay and then streams the rest, the client's next request regularly lands inside a background fill. This reaches both the stall case and the early hit on an arrived word. An uncached window of 1 KB, inside a 4 KB memory model, exercises the bypass path alongside the cached traffic.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CRIT_WAIT,
        ST_BACKFILL,
        ST_NC_WAIT,
        ST_NC_DRAIN
    } dmc_state_e;

endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
    parameter  int LINES = 64,
    parameter  int TAG_W = 22,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [TAG_W-1:0] set_tag
);

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (clr_en) valid_q[clr_idx] <= 1'b0;
            if (set_en) valid_q[set_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (set_en) tag_q[set_idx] <= set_tag;
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];

endmodule

// File: rtl/dmc_data_array.sv
module dmc_data_array #(
    parameter  int LINES      = 64,
    parameter  int LINE_WORDS = 4,
    parameter  int WORD_W     = 32,
    localparam int IDX_W      = $clog2(LINES),
    localparam int OFF_W      = $clog2(LINE_WORDS),
    localparam int DEPTH      = LINES * LINE_WORDS
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [WORD_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [WORD_W-1:0] wr_data
);

    logic [WORD_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) store_q[{wr_idx, wr_off}] <= wr_data;
    end

    assign rd_data = store_q[{rd_idx, rd_off}];

endmodule

// File: rtl/dmc_fill_ctrl.sv
module dmc_fill_ctrl
    import dmc_pkg::*;
#(
    parameter  int LINE_WORDS = 4,
    localparam int OFF_W      = $clog2(LINE_WORDS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_fill,
    input  logic                  start_nc,
    input  logic [OFF_W-1:0]      start_off,
    input  logic                  beat_valid,
    output dmc_state_e            state,
    output logic [OFF_W-1:0]      beat_word,
    output logic [LINE_WORDS-1:0] arrived,
    output logic                  first_beat,
    output logic                  last_beat,
    output logic                  fill_beat
);

    dmc_state_e state_q, state_d;
    logic [OFF_W-1:0]      beat_q, start_q;
    logic [LINE_WORDS-1:0] arrived_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_fill)    state_d = ST_CRIT_WAIT;
                else if (start_nc) state_d = ST_NC_WAIT;
            end
            ST_CRIT_WAIT: if (beat_valid) state_d = ST_BACKFILL;
            ST_BACKFILL:  if (last_beat)  state_d = ST_IDLE;
            ST_NC_WAIT:   if (beat_valid) state_d = ST_NC_DRAIN;
            ST_NC_DRAIN:  if (last_beat)  state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    // beat counter and arrival mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q    <= '0;
            start_q   <= '0;
            arrived_q <= '0;
        end else if (start_fill || start_nc) begin
            beat_q    <= '0;
            start_q   <= start_off;
            arrived_q <= '0;
        end else if (beat_valid && state_q != ST_IDLE) begin
            beat_q <= beat_q + 1'b1;
            if (state_q == ST_CRIT_WAIT || state_q == ST_BACKFILL)
                arrived_q[beat_word] <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        state      = state_q;
        arrived    = arrived_q;
        beat_word  = start_q + beat_q;
        first_beat = beat_valid && (state_q == ST_CRIT_WAIT || state_q == ST_NC_WAIT);
        last_beat  = beat_valid && (beat_q == OFF_W'(LINE_WORDS - 1))
                     && (state_q == ST_BACKFILL || state_q == ST_NC_DRAIN);
        fill_beat  = beat_valid && (state_q == ST_CRIT_WAIT || state_q == ST_BACKFILL);
    end

endmodule

// File: rtl/dm_cache.sv
module dm_cache
    import dmc_pkg::*;
#(
    parameter  int ADDR_W     = 32,
    parameter  int WORD_W     = 32,
    parameter  int LINE_WORDS = 4,
    parameter  int LINES      = 64,
    parameter  int CNT_W      = 32,
    localparam int BYTE_W     = $clog2(WORD_W / 8),
    localparam int OFF_W      = $clog2(LINE_WORDS),
    localparam int IDX_W      = $clog2(LINES),
    localparam int TAG_W      = ADDR_W - BYTE_W - OFF_W - IDX_W,
    localparam int WADDR_W    = ADDR_W - BYTE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  nc_base,
    input  logic [ADDR_W-1:0]  nc_mask,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [WORD_W-1:0]  req_wdata,
    output logic               req_ready,
    output logic               rsp_valid,
    output logic [WORD_W-1:0]  rsp_rdata,
    output logic               mem_rd_req,
    output logic [WADDR_W-1:0] mem_rd_addr,
    input  logic               mem_rd_valid,
    input  logic [WORD_W-1:0]  mem_rd_data,
    output logic               mem_wr_valid,
    output logic [WADDR_W-1:0] mem_wr_addr,
    output logic [WORD_W-1:0]  mem_wr_data,
    output logic [CNT_W-1:0]   hit_count,
    output logic [CNT_W-1:0]   miss_count
);

    // address split
    logic [OFF_W-1:0] req_off;
    logic [IDX_W-1:0] req_idx;
    logic [TAG_W-1:0] req_tag;
    logic             cacheable;

    assign req_off   = req_addr[BYTE_W +: OFF_W];
    assign req_idx   = req_addr[BYTE_W + OFF_W +: IDX_W];
    assign req_tag   = req_addr[ADDR_W-1 -: TAG_W];
    assign cacheable = (req_addr & nc_mask) != nc_base;

    // internal wiring
    dmc_state_e            fsm_state;
    logic [OFF_W-1:0]      beat_word;
    logic [LINE_WORDS-1:0] arrived;
    logic                  first_beat, last_beat, fill_beat;
    logic                  line_valid;
    logic [TAG_W-1:0]      line_tag;
    logic [WORD_W-1:0]     dr_data;
    logic [IDX_W-1:0]      fill_idx_q;
    logic [TAG_W-1:0]      fill_tag_q;

    logic tag_hit, fill_match, acc;
    logic rd_hit_acc, rd_miss_acc, start_fill, start_nc;
    logic wr_acc, wr_hit, tag_set;

    assign tag_hit     = cacheable && line_valid && (line_tag == req_tag);
    assign fill_match  = cacheable && !req_write && (req_idx == fill_idx_q)
                         && (req_tag == fill_tag_q) && arrived[req_off];
    assign req_ready   = (fsm_state == ST_IDLE) || (fsm_state == ST_BACKFILL && fill_match);
    assign acc         = req_valid && req_ready;
    assign rd_hit_acc  = acc && !req_write && ((fsm_state == ST_IDLE) ? tag_hit : fill_match);
    assign rd_miss_acc = acc && !req_write && (fsm_state == ST_IDLE) && !tag_hit;
    assign start_fill  = rd_miss_acc && cacheable;
    assign start_nc    = rd_miss_acc && !cacheable;
    assign wr_acc      = acc && req_write;
    assign wr_hit      = wr_acc && tag_hit;
    assign tag_set     = last_beat && (fsm_state == ST_BACKFILL);

    dmc_fill_ctrl #(.LINE_WORDS(LINE_WORDS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_fill (start_fill),
        .start_nc   (start_nc),
        .start_off  (req_off),
        .beat_valid (mem_rd_valid),
        .state      (fsm_state),
        .beat_word  (beat_word),
        .arrived    (arrived),
        .first_beat (first_beat),
        .last_beat  (last_beat),
        .fill_beat  (fill_beat)
    );

    dmc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (req_idx),
        .rd_valid (line_valid),
        .rd_tag   (line_tag),
        .clr_en   (start_fill),
        .clr_idx  (req_idx),
        .set_en   (tag_set),
        .set_idx  (fill_idx_q),
        .set_tag  (fill_tag_q)
    );

    dmc_data_array #(.LINES(LINES), .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W)) u_data (
        .clk     (clk),
        .rd_idx  (req_idx),
        .rd_off  (req_off),
        .rd_data (dr_data),
        .wr_en   (fill_beat || wr_hit),
        .wr_idx  (fill_beat ? fill_idx_q : req_idx),
        .wr_off  (fill_beat ? beat_word : req_off),
        .wr_data (fill_beat ? mem_rd_data : req_wdata)
    );

    // response, memory-side and counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_rdata    <= '0;
            mem_rd_req   <= 1'b0;
            mem_rd_addr  <= '0;
            mem_wr_valid <= 1'b0;
            mem_wr_addr  <= '0;
            mem_wr_data  <= '0;
            fill_idx_q   <= '0;
            fill_tag_q   <= '0;
            hit_count    <= '0;
            miss_count   <= '0;
        end else begin
            rsp_valid <= rd_hit_acc || first_beat;
            if (rd_hit_acc)      rsp_rdata <= dr_data;
            else if (first_beat) rsp_rdata <= mem_rd_data;

            mem_rd_req <= rd_miss_acc;
            if (rd_miss_acc) mem_rd_addr <= req_addr[ADDR_W-1:BYTE_W];

            mem_wr_valid <= wr_acc;
            if (wr_acc) begin
                mem_wr_addr <= req_addr[ADDR_W-1:BYTE_W];
                mem_wr_data <= req_wdata;
            end

            if (start_fill) begin
                fill_idx_q <= req_idx;
                fill_tag_q <= req_tag;
            end

            if (rd_hit_acc)  hit_count  <= hit_count + CNT_W'(1);
            if (rd_miss_acc) miss_count <= miss_count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/dm_cache_chk.sv
module dm_cache_chk
    import dmc_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_rd_req,
    input logic              mem_wr_valid,
    input logic [WORD_W-1:0] mem_wr_data,
    input logic [WORD_W-1:0] req_wdata,
    input logic              rd_hit_acc,
    input logic              rd_miss_acc,
    input logic              first_beat,
    input logic              wr_acc,
    input logic              tag_set,
    input dmc_state_e        fsm_state
);

    AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit_acc |=> rsp_valid); // R2

    AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_miss_acc |=> !req_ready); // R3

    AST_MISS_REQUESTS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        rd_miss_acc |=> mem_rd_req); // R3

    AST_RDREQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req); // R3

    AST_EARLY_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        first_beat |=> rsp_valid); // R5

    AST_NO_WRITE_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state != ST_IDLE && req_valid && req_write) |-> !req_ready); // R6

    AST_FILL_ENDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        tag_set |=> (fsm_state == ST_IDLE)); // R7

    AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |=> (mem_wr_valid && mem_wr_data == $past(req_wdata))); // R10

endmodule

bind dm_cache dm_cache_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/dm_cache_bench.sv
module dm_cache_bench;

    localparam int LINES = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] nc_base = 32'h0000_0C00;
    logic [31:0] nc_mask = 32'hFFFF_FC00;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [31:0] rsp_rdata;
    logic        mem_rd_req, mem_rd_valid = 1'b0;
    logic [29:0] mem_rd_addr;
    logic [31:0] mem_rd_data = '0;
    logic        mem_wr_valid;
    logic [29:0] mem_wr_addr;
    logic [31:0] mem_wr_data;
    logic [31:0] hit_count, miss_count;

    int checks = 0, errors = 0;
    int exp_hits = 0, exp_misses = 0;
    int beats_seen = 0;

    logic [31:0] mem_model [1024];
    logic [31:0] ref_mem   [1024];
    logic        ref_valid [LINES];
    logic [24:0] ref_tag   [LINES];

    always #10ns clk = ~clk;

    dm_cache #(.LINES(LINES)) u_dm_cache (
        .clk(clk), .rst_n(rst_n), .nc_base(nc_base), .nc_mask(nc_mask),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .hit_count(hit_count), .miss_count(miss_count)
    );

    // backing memory: fixed delay, then 4 beats in wrap order
    int          m_lat = 0, m_left = 0, m_beat = 0;
    logic [29:0] m_start = '0;
    always @(negedge clk) begin
        mem_rd_valid = 1'b0;
        if (mem_wr_valid) mem_model[mem_wr_addr[9:0]] = mem_wr_data;
        if (m_left > 0) begin
            if (m_lat > 0) m_lat--;
            else begin
                mem_rd_valid = 1'b1;
                mem_rd_data  = mem_model[{m_start[9:2], 2'(m_start[1:0] + 2'(m_beat))}];
                m_beat++;
                m_left--;
            end
        end else if (mem_rd_req) begin
            m_lat = 2; m_left = 4; m_beat = 0; m_start = mem_rd_addr;
        end
    end

    always @(posedge clk) begin
        if (mem_rd_req)        beats_seen <= 0;
        else if (mem_rd_valid) beats_seen <= beats_seen + 1;
    end

    task automatic check(input bit ok, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic bit is_nc(input logic [31:0] a);
        return (a & nc_mask) == nc_base;
    endfunction

    // reference lookup; installs on cacheable read miss
    function automatic bit ref_read(input logic [31:0] a);
        bit hit;
        hit = !is_nc(a) && ref_valid[a[6:4]] && ref_tag[a[6:4]] == a[31:7];
        if (hit) exp_hits++;
        else begin
            exp_misses++;
            if (!is_nc(a)) begin
                ref_valid[a[6:4]] = 1'b1;
                ref_tag[a[6:4]]   = a[31:7];
            end
        end
        return hit;
    endfunction

    task automatic do_read(input logic [31:0] a, input string what);
        bit          exp_hit;
        logic [31:0] exp_d;
        int          lat;
        exp_d   = ref_mem[a[11:2]];
        exp_hit = ref_read(a);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        #1ns;
        while (!req_ready) begin @(negedge clk); #1ns; end
        @(posedge clk); #1ns;
        req_valid = 1'b0;
        @(negedge clk);
        lat = 0;
        if (!exp_hit) begin
            check(mem_rd_req && mem_rd_addr == a[31:2],
                  {what, " R3 critical-word request address"}, {2'b0, mem_rd_addr}, {2'b0, a[31:2]});
            check(!req_ready, {what, " R3 stall after miss"}, 32'(req_ready), 32'd0);
        end
        while (!rsp_valid) begin @(negedge clk); lat++; end
        check(rsp_rdata == exp_d, {what, " R2 R4 read data"}, rsp_rdata, exp_d);
        if (exp_hit)
            check(lat == 0, {what, " R2 hit latency"}, 32'(lat), 32'd0);
        else
            check(beats_seen == 1, {what, " R5 early restart beat count"}, 32'(beats_seen), 32'd1);
    endtask

    task automatic do_write(input logic [31:0] a, input logic [31:0] d, input string what);
        ref_mem[a[11:2]] = d;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        #1ns;
        while (!req_ready) begin @(negedge clk); #1ns; end
        @(posedge clk); #1ns;
        req_valid = 1'b0; req_write = 1'b0;
        @(negedge clk);
        check(mem_wr_valid && mem_wr_addr == a[31:2] && mem_wr_data == d,
              {what, " R10 write-through"}, mem_wr_data, d);
    endtask

    task automatic check_counters(input string what);
        check(hit_count == 32'(exp_hits), {what, " R13 hit counter"}, hit_count, 32'(exp_hits));
        check(miss_count == 32'(exp_misses), {what, " R13 miss counter"}, miss_count, 32'(exp_misses));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int m0;
        void'($urandom(32'd2024));
        for (int i = 0; i < 1024; i++) begin
            mem_model[i] = (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
            ref_mem[i]   = mem_model[i];
        end
        for (int i = 0; i < LINES; i++) begin ref_valid[i] = 1'b0; ref_tag[i] = '0; end

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(req_ready == 1'b1, "R12 ready after reset", 32'(req_ready), 32'd1);
        check(!rsp_valid && !mem_rd_req, "R12 no response or request", 32'(rsp_valid), 32'd0);
        check(hit_count == 0 && miss_count == 0, "R12 counters zero", hit_count | miss_count, 32'd0);

        // R12 R4 R5: first read misses, demanded word 2 first
        do_read(32'h0000_0108, "cold");
        // R6: word 0 of the filling line not yet arrived -> stall
        req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h0000_0100;
        #1ns;
        check(!req_ready, "R6 R7 unarrived word stalls", 32'(req_ready), 32'd0);
        // R6: arrived word accepted during fill
        req_addr = 32'h0000_0108;
        #1ns;
        check(req_ready, "R6 arrived word accepted", 32'(req_ready), 32'd1);
        void'(ref_read(32'h0000_0108));
        @(posedge clk); #1ns;
        req_valid = 1'b0;
        @(negedge clk);
        check(rsp_valid && rsp_rdata == ref_mem[10'h042], "R6 in-fill hit data",
              rsp_rdata, ref_mem[10'h042]);
        // R6: other line stalls while fill continues
        req_valid = 1'b1; req_addr = 32'h0000_0200;
        #1ns;
        check(!req_ready, "R6 other line stalls", 32'(req_ready), 32'd0);
        req_valid = 1'b0;

        do_read(32'h0000_010C, "R7 R1 other word after fill");
        do_read(32'h0000_0200, "R8 conflict miss");
        do_read(32'h0000_0104, "R8 evicted tag misses");
        check_counters("directed");

        // R9 uncached window
        m0 = int'(miss_count);
        do_read(32'h0000_0C40, "R9 window read 1");
        do_read(32'h0000_0C40, "R9 window read 2");
        check(miss_count == 32'(m0 + 2), "R9 window reads both miss", miss_count, 32'(m0 + 2));

        // R10 write hit then read hit with new data
        do_write(32'h0000_0108, 32'hCAFE_F00D, "R10 write hit");
        do_read(32'h0000_0108, "R10 read after write hit");

        // R11 write miss no allocate
        m0 = int'(miss_count);
        do_write(32'h0000_0354, 32'h1234_5678, "R11 write miss");
        do_read(32'h0000_0354, "R11 read after write miss");
        check(miss_count == 32'(m0 + 1), "R11 write did not allocate", miss_count, 32'(m0 + 1));
        check_counters("after writes");

        // constrained random mix
        for (int n = 0; n < 600; n++) begin
            logic [31:0] a;
            if ($urandom % 5 == 0) a = 32'h0000_0C00 + (($urandom % 64) << 2);
            else                   a = ($urandom % 128) << 2;
            if ($urandom % 4 == 0) do_write(a, $urandom, "random");
            else                   do_read(a, "random");
        end
        check_counters("random");

        repeat (6) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule